// File: doc/BRIEF.md
# Asynchronous PSRAM Word Writer

This block moves 16-bit words out of an on-chip line FIFO into an external asynchronous pseudo-static RAM. It does not use burst mode. Every word is written in its own independent cycle. In that cycle, chip select and write enable drop together and stay low for a fixed pulse time. Both strobes then return high for a fixed recovery gap before the next word can start. The two times are given in nanoseconds and converted to clock cycles, rounding up. With the default 10 ns clock the pulse lasts 8 cycles and the gap 2 cycles, so words leave at one per 100 ns at best. Any upstream logic that must drop data to keep up with a line depends on this fixed pitch.

The FIFO is read in show-ahead style. The head word is visible on `fifo_data` whenever `fifo_empty` is low, and `fifo_rd` pops it. The address and data for a word are registered on the edge where chip select falls. They then stay unchanged until the next word is launched. Addresses step linearly through the frame buffer from zero. A `start` pulse brings the next write back to address zero, and so does reset. The `idle` output reports that nothing is being written and nothing is waiting.

Top module: `psram_word_writer`

## Requirements
- R1: While `rst_n` is low:
  - `mem_cs_n` and `mem_we_n` are 1.
  - `fifo_rd` is 0.
  - `mem_addr` and `mem_data` are 0.
  - `idle` equals `fifo_empty`.
  - The first word written after reset goes to address 0.
- R2: For each word, `mem_cs_n` and `mem_we_n` fall on the same edge and stay low for exactly WE_CYC cycles, where WE_CYC = ceil(WE_LOW_NS / CLK_NS), at least 1 (8 with defaults). `mem_we_n` equals `mem_cs_n` at all times.
- R3: After each write, `mem_cs_n` stays high for at least GAP_CYC cycles, where GAP_CYC = ceil(CS_GAP_NS / CLK_NS), at least 1 (2 with defaults). If a word is already waiting when the strobes rise, the next fall comes exactly GAP_CYC cycles later, giving a pitch of WE_CYC + GAP_CYC cycles.
- R4: `fifo_rd` is high for one cycle, exactly the cycle before `mem_cs_n` falls, and never while `fifo_empty` is high. The word written is the `fifo_data` value present in that cycle. Every word is written once, in FIFO order.
- R5: `mem_addr` and `mem_data` change only on the edge where `mem_cs_n` falls. They hold their values through the write pulse and the gap that follows.
- R6: After a `start` pulse, the next word goes to address 0. Each later word goes to the previous address plus 1, modulo 2^ADDR_W.
- R7: A `start` pulse during a write leaves that write's address, data and timing unchanged. The word after it goes to address 0. If `start` coincides with `fifo_rd`, the word being popped goes to address 0.
- R8: `idle` is high exactly when no write pulse or gap is in progress and `fifo_empty` is high. After the last pending word, `idle` rises on the edge that ends its gap.
- R9: When the block is idle and a word appears, `fifo_rd` rises in the same cycle (combinational from `fifo_empty`), and `mem_cs_n` falls at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, period CLK_NS |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that rewinds the write address to zero |
| fifo_empty | input | 1 | Line FIFO has no word available |
| fifo_data | input | DATA_W | Head word of the show-ahead line FIFO |
| fifo_rd | output | 1 | Pops the head word from the FIFO |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory word address |
| mem_data | output | DATA_W | Memory write data |
| idle | output | 1 | No write in progress and FIFO empty |

## Verification
The writer is driven by five word-arrival patterns:
- **All words at once.** This fixes the back-to-back pitch of exactly WE_CYC + GAP_CYC cycles.
- **A word every 4 or 10 cycles.** Words land during the write pulse or at the edge of the gap. This separates "wait for the gap to end" from "start as soon as a word is present".
- **Words 26 cycles apart.** Each word finds the block idle. This shows the one-cycle launch latency and that `idle` rises right after the gap.
- **Start pulse mid-write.** This shows that rewinding the address does not disturb the word already on the bus.
- **Reset with a word already waiting.** This shows that nothing is popped during reset and that the address counter is cleared.

For every word the bench checks the address sequence, the data order, the pulse length, the gap length and bus stability.

// File: rtl/psram_wr_pkg.sv
// Package: shared state encoding and timing helper for the PSRAM word writer.
// Assumes all time values are whole nanoseconds and the clock period is non-zero.
package psram_wr_pkg;

    // Phases of one single-word write cycle.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_GAP   = 2'd2
    } wr_state_e;

    // Convert a duration in ns into clock cycles, rounding up, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned dur_ns,
                                                 input int unsigned clk_ns);
        int unsigned cyc;
        cyc = (dur_ns + clk_ns - 1) / clk_ns;
        return (cyc == 0) ? 1 : cyc;
    endfunction

endpackage

// File: rtl/psram_wr_seq.sv
// Module: psram_wr_seq
// Sequences one write cycle at a time: a strobe-low phase of WE_CYC cycles
// followed by a strobe-high gap of GAP_CYC cycles. A new word is launched
// from idle, or on the last gap cycle, whenever the FIFO offers one.
// Assumes WE_CYC >= 1 and GAP_CYC >= 1 and a show-ahead FIFO.
module psram_wr_seq
    import psram_wr_pkg::*;
#(
    parameter int unsigned WE_CYC  = 8,
    parameter int unsigned GAP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty,
    output logic launch,
    output logic wr_end,
    output logic seq_idle
);

    localparam int unsigned MAX_CYC = (WE_CYC > GAP_CYC) ? WE_CYC : GAP_CYC;
    localparam int unsigned TMR_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [TMR_W-1:0] WE_LOAD  = TMR_W'(WE_CYC - 1);
    localparam logic [TMR_W-1:0] GAP_LOAD = TMR_W'(GAP_CYC - 1);

    wr_state_e        state_q, state_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic             tmr_zero;
    logic             gap_end;

    assign tmr_zero = (tmr_q == '0);
    assign gap_end  = (state_q == ST_GAP) && tmr_zero;
    assign wr_end   = (state_q == ST_WRITE) && tmr_zero;
    assign seq_idle = (state_q == ST_IDLE);
    // Launch only out of reset, with a word present, and no cycle still running.
    assign launch   = rst_n && !fifo_empty && ((state_q == ST_IDLE) || gap_end);

    // Next-state and phase timer for the write cycle.
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        case (state_q)
            ST_IDLE: begin
                if (launch) begin
                    state_d = ST_WRITE;
                    tmr_d   = WE_LOAD;
                end
            end
            ST_WRITE: begin
                if (tmr_zero) begin
                    state_d = ST_GAP;
                    tmr_d   = GAP_LOAD;
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
            ST_GAP: begin
                if (launch) begin
                    state_d = ST_WRITE;
                    tmr_d   = WE_LOAD;
                end else if (tmr_zero) begin
                    state_d = ST_IDLE;
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                tmr_d   = '0;
            end
        endcase
    end

    // State and timer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

endmodule

// File: rtl/psram_wr_addr.sv
// Module: psram_wr_addr
// Linear word-address counter. Supplies the address for the word being
// launched and advances by one per launch. A start pulse rewinds it to zero
// and takes priority, so a word launched in the same cycle uses address zero.
// Assumes start is a single-cycle pulse; wraps modulo 2^ADDR_W.
module psram_wr_addr #(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              launch,
    output logic [ADDR_W-1:0] word_addr
);

    logic [ADDR_W-1:0] cnt_q;

    assign word_addr = start ? '0 : cnt_q;

    // Rewind on start, post-increment on every launched word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start || launch) begin
            cnt_q <= word_addr + ADDR_W'(launch);
        end
    end

endmodule

// File: rtl/psram_wr_bus.sv
// Module: psram_wr_bus
// Output register stage for the memory pins. Chip select, write enable,
// address and data all load on the launch edge; the strobes release on the
// last pulse cycle while address and data stay put until the next launch.
// Assumes launch and wr_end never coincide (guaranteed by the sequencer).
module psram_wr_bus #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              wr_end,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              cs_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    // Strobe registers: drop together at launch, rise together at pulse end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            we_n <= 1'b1;
        end else if (launch) begin
            cs_n <= 1'b0;
            we_n <= 1'b0;
        end else if (wr_end) begin
            cs_n <= 1'b1;
            we_n <= 1'b1;
        end
    end

    // Address and data registers: captured only when a word is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            data <= '0;
        end else if (launch) begin
            addr <= addr_in;
            data <= data_in;
        end
    end

endmodule

// File: rtl/psram_word_writer.sv
// Module: psram_word_writer (top)
// Drains a show-ahead line FIFO into an asynchronous PSRAM using one
// independent, fixed-length write cycle per 16-bit word: strobes low for
// WE_LOW_NS, then high for CS_GAP_NS before the next word. Times are turned
// into clock cycles with round-up. Addresses run linearly from zero after
// reset or a start pulse.
// Assumes the FIFO presents its head word whenever fifo_empty is low.
module psram_word_writer
    import psram_wr_pkg::*;
#(
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned WE_LOW_NS = 80,
    parameter int unsigned CS_GAP_NS = 20,
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              idle
);

    localparam int unsigned WE_CYC  = ns_to_cycles(WE_LOW_NS, CLK_NS);
    localparam int unsigned GAP_CYC = ns_to_cycles(CS_GAP_NS, CLK_NS);

    logic              launch;
    logic              wr_end;
    logic              seq_idle;
    logic [ADDR_W-1:0] word_addr;

    psram_wr_seq #(
        .WE_CYC  (WE_CYC),
        .GAP_CYC (GAP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .launch     (launch),
        .wr_end     (wr_end),
        .seq_idle   (seq_idle)
    );

    psram_wr_addr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .launch    (launch),
        .word_addr (word_addr)
    );

    psram_wr_bus #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .wr_end  (wr_end),
        .addr_in (word_addr),
        .data_in (fifo_data),
        .cs_n    (mem_cs_n),
        .we_n    (mem_we_n),
        .addr    (mem_addr),
        .data    (mem_data)
    );

    assign fifo_rd = launch;
    assign idle    = seq_idle && fifo_empty;

endmodule

// File: rtl/psram_wr_checker.sv
// Module: psram_wr_checker
// Protocol checks on the PSRAM writer pins, bound into the top module.
// Pulse and gap lengths are measured with saturating counters so that no
// property window depends on a parameter value.
module psram_wr_checker #(
    parameter int unsigned WE_CYC  = 8,
    parameter int unsigned GAP_CYC = 2,
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned DATA_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_empty,
    input logic              fifo_rd,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              idle
);

    logic [15:0] low_cnt;
    logic [15:0] hi_cnt;

    // Count consecutive low and high strobe samples, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            hi_cnt  <= 16'hFFFF;
        end else if (!mem_cs_n) begin
            low_cnt <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 16'd1;
            hi_cnt  <= '0;
        end else begin
            low_cnt <= '0;
            hi_cnt  <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1;
        end
    end

    p_reset_no_pop_r1: assert property (@(posedge clk) !rst_n |-> !fifo_rd);
    p_reset_strobes_r1: assert property (@(posedge clk) !rst_n |=> (mem_cs_n && mem_we_n));
    p_strobes_paired_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_n == mem_cs_n);
    p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> low_cnt == 16'(WE_CYC));
    p_gap_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> hi_cnt >= 16'(GAP_CYC));
    p_pop_then_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> $fell(mem_cs_n));
    p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_rd);
    p_bus_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rd |=> ($stable(mem_addr) && $stable(mem_data)));
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (mem_cs_n && !fifo_rd));

endmodule

bind psram_word_writer psram_wr_checker #(
    .WE_CYC  (WE_CYC),
    .GAP_CYC (GAP_CYC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .idle       (idle)
);

// File: tb/psram_word_writer_test.sv
`timescale 1ns/1ps
module psram_word_writer_test;

    localparam int CLK_PERIOD = 10;
    localparam int WE_NS      = 80;
    localparam int GAP_NS     = 20;
    localparam int AW         = 20;
    localparam int DW         = 16;
    localparam int WE_EXP     = (WE_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int GAP_EXP    = (GAP_NS + CLK_PERIOD - 1) / CLK_PERIOD;

    // Row: [31] start pulse first, [30:24] word count, [23:16] extra cycles
    // between pushes, [15:0] first data word.
    localparam int NV = 6;
    localparam logic [31:0] VEC [NV] = '{
        {1'b1, 7'd4, 8'd0,  16'hA000},
        {1'b0, 7'd3, 8'd0,  16'h1234},
        {1'b0, 7'd3, 8'd3,  16'h5A5A},
        {1'b0, 7'd3, 8'd9,  16'h0F0F},
        {1'b0, 7'd2, 8'd25, 16'hFFFF},
        {1'b1, 7'd5, 8'd1,  16'h0001}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          fifo_empty = 1'b1;
    logic [DW-1:0] fifo_data = '0;
    logic          fifo_rd;
    logic          mem_cs_n;
    logic          mem_we_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          idle;

    int n_chk = 0;
    int n_fail = 0;

    logic [DW-1:0] fq[$];
    logic [DW-1:0] eq[$];
    logic [AW-1:0] exp_addr = '0;
    logic          rd_flag = 1'b0;

    psram_word_writer #(
        .CLK_NS    (CLK_PERIOD),
        .WE_LOW_NS (WE_NS),
        .CS_GAP_NS (GAP_NS),
        .ADDR_W    (AW),
        .DATA_W    (DW)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_rd    (fifo_rd),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .idle       (idle)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic refresh_fifo();
        fifo_empty = (fq.size() == 0);
        fifo_data  = (fq.size() == 0) ? '0 : fq[0];
    endtask

    task automatic push_word(input logic [DW-1:0] w);
        @(posedge clk); #2;
        fq.push_back(w);
        eq.push_back(w);
        refresh_fifo();
    endtask

    task automatic pulse_start();
        @(posedge clk); #2;
        start = 1'b1;
        exp_addr = '0;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(idle && mem_cs_n && fq.size() == 0));
        @(negedge clk);
    endtask

    // FIFO model: pop after an edge at which the design requested a word.
    always @(posedge clk) begin
        #1;
        if (rd_flag) begin
            if (fq.size() > 0) void'(fq.pop_front());
            rd_flag = 1'b0;
            refresh_fifo();
        end
    end

    // Bus monitor, sampling mid-cycle.
    logic          prev_cs = 1'b1;
    logic          rd_prev = 1'b0;
    logic          seen_wr = 1'b0;
    logic          in_gap = 1'b0;
    logic          pend_at_rise = 1'b0;
    int            low_len = 0;
    int            gap_len = 0;
    logic [AW-1:0] held_addr = '0;
    logic [DW-1:0] held_data = '0;
    always @(negedge clk) begin
        logic          fall;
        logic          rise;
        logic [DW-1:0] exp_d;
        if (!rst_n) begin
            prev_cs = 1'b1; rd_prev = 1'b0; seen_wr = 1'b0; in_gap = 1'b0;
            rd_flag = 1'b0; low_len = 0; gap_len = 0;
        end else begin
            fall = !mem_cs_n && prev_cs;
            rise = mem_cs_n && !prev_cs;
            if (fifo_rd) chk(!fifo_empty, "R4 pop while FIFO empty", fifo_empty, 0);
            if (rd_prev || fall)
                chk(rd_prev && fall, "R4 pop must precede chip select fall by one cycle",
                    {rd_prev, fall}, 2'b11);
            if (fall) begin
                chk(eq.size() > 0, "R4 write with no word pending", eq.size(), 1);
                exp_d = (eq.size() > 0) ? eq.pop_front() : '0;
                chk(mem_data == exp_d, "R4 written data", mem_data, exp_d);
                chk(mem_addr == exp_addr, "R6 write address", mem_addr, exp_addr);
                chk(!mem_we_n, "R2 write enable falls with chip select", mem_we_n, 0);
                exp_addr = exp_addr + 1'b1;
                if (in_gap) begin
                    if (pend_at_rise) chk(gap_len == GAP_EXP, "R3 gap length with word waiting", gap_len, GAP_EXP);
                    else chk(gap_len >= GAP_EXP, "R3 minimum gap length", gap_len, GAP_EXP);
                end
                in_gap = 1'b0;
                low_len = 1;
                held_addr = mem_addr;
                held_data = mem_data;
                seen_wr = 1'b1;
            end else if (!mem_cs_n) begin
                low_len++;
                chk(!mem_we_n, "R2 write enable low during pulse", mem_we_n, 0);
                chk(mem_addr == held_addr && mem_data == held_data, "R5 bus held during pulse",
                    {mem_addr, mem_data}, {held_addr, held_data});
            end else begin
                chk(mem_we_n, "R2 write enable high with chip select", mem_we_n, 1);
                if (rise) begin
                    chk(low_len == WE_EXP, "R2 pulse length", low_len, WE_EXP);
                    in_gap = 1'b1;
                    gap_len = 0;
                    pend_at_rise = (fq.size() > 0);
                end
                if (seen_wr)
                    chk(mem_addr == held_addr && mem_data == held_data, "R5 bus held during gap",
                        {mem_addr, mem_data}, {held_addr, held_data});
                if (in_gap) begin
                    if (idle) begin
                        chk(gap_len == GAP_EXP, "R8 idle rises right after gap", gap_len, GAP_EXP);
                        in_gap = 1'b0;
                    end else begin
                        gap_len++;
                    end
                end
            end
            prev_cs = mem_cs_n;
            rd_prev = fifo_rd;
            rd_flag = fifo_rd;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: idle never reached, actual=timeout expected=done");
        report();
        $finish;
    end

    initial begin
        // R1: reset state with an empty FIFO.
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n, "R1 strobes high in reset", {mem_cs_n, mem_we_n}, 2'b11);
        chk(!fifo_rd, "R1 no pop in reset", fifo_rd, 0);
        chk(idle, "R1 idle follows empty FIFO in reset", idle, 1);
        chk(mem_addr == '0 && mem_data == '0, "R1 bus cleared in reset", mem_addr, 0);
        @(posedge clk); #2; rst_n = 1'b1;

        // Vector table: R2 R3 R4 R5 R6 under several arrival patterns.
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][31]) pulse_start();
            for (int i = 0; i < int'(VEC[v][30:24]); i++) begin
                push_word(VEC[v][15:0] + DW'(i * 16'h0111));
                repeat (int'(VEC[v][23:16])) @(posedge clk);
            end
            wait_idle();
            chk(eq.size() == 0, "R4 every pushed word written", eq.size(), 0);
            chk(idle, "R8 idle after draining", idle, 1);
        end

        // R9: launch latency from idle.
        repeat (4) @(negedge clk);
        push_word(16'hBEEF);
        @(negedge clk);
        chk(fifo_rd, "R9 pop in the cycle the word appears", fifo_rd, 1);
        chk(!idle, "R8 idle drops with a word present", idle, 0);
        @(negedge clk);
        chk(!mem_cs_n, "R9 chip select falls next edge", mem_cs_n, 0);
        wait_idle();

        // R1: reset with a word waiting; counter must return to zero.
        @(posedge clk); #2; rst_n = 1'b0;
        push_word(16'h7E57);
        repeat (2) @(negedge clk);
        chk(!fifo_rd, "R1 no pop in reset with word waiting", fifo_rd, 0);
        chk(mem_cs_n, "R1 no write in reset", mem_cs_n, 1);
        chk(mem_addr == '0, "R1 address cleared by reset", mem_addr, 0);
        chk(!idle, "R1 idle low with word waiting", idle, 0);
        exp_addr = '0;
        @(posedge clk); #2; rst_n = 1'b1;
        wait_idle();
        chk(mem_addr == '0 && mem_data == 16'h7E57, "R1 first word after reset at address 0",
            {mem_addr, mem_data}, {20'h0, 16'h7E57});

        // R7: start during a write; in-flight word undisturbed, next at zero.
        push_word(16'hC001);
        push_word(16'hC002);
        do @(negedge clk); while (mem_cs_n);
        pulse_start();
        wait_idle();
        chk(mem_addr == '0 && mem_data == 16'hC002, "R7 word after mid-write start at address 0",
            {mem_addr, mem_data}, {20'h0, 16'hC002});
        chk(eq.size() == 0, "R7 both words written", eq.size(), 0);

        report();
        $finish;
    end

endmodule